// File: doc/BRIEF.md
# Three-Channel Edge Skew Detector

This block measures the relative arrival time of three sliced, single-bit channel signals (red, green and blue). Each channel is paired with a partner. For every pair the block drives a sign-tagged pulse that is active from the first rising edge of the pair to the second one. A downstream averaging stage turns the duty of that pulse into a skew figure. The sign tells which member of the pair arrived first. The block samples all inputs on its own clock, so the skew is resolved in whole sample periods.

In normal mode the probes use the delayed copies of the channels and compare them in rotation: red against green, green against blue, and blue against red. In test mode each of the outer probes compares a channel's undelayed input with its own delayed copy, which shows the delay that was programmed for that channel. The middle probe is silent in test mode, because its output pin is then used for the slice level. A change of mode discards any measurement in progress.

Top module: `skew_probe_top`

## Requirements
- R1: While reset is asserted, and until a measurement starts afterwards, every `probe_act` and `probe_pos` bit is 0.
- R2: In normal mode (`test_mode`=0), probe i compares `ch_dly[i]` (side A) with `ch_dly[(i+1) mod 3]` (side B). Bit 0 is red, bit 1 is green and bit 2 is blue.
- R3: When side A rises first and side B rises d cycles later while A is still high, `probe_act` is 1 for exactly d cycles and `probe_pos` is 1 throughout.
- R4: When side B rises first and side A rises d cycles later while B is still high, `probe_act` is 1 for exactly d cycles and `probe_pos` is 0 throughout.
- R5: A change on a channel input first shows on the probe outputs after the third rising clock edge that follows it (SYNC_STAGES+1 edges).
- R6: Rising edges of A and B that fall in the same sample period produce no pulse.
- R7: When the leading side falls before the lagging side rises, the measurement is dropped: `probe_act` returns to 0 three edges after the fall, whether or not the lagging side ever rises.
- R8: In test mode, probe 0 compares `ch_in[0]` (A) with `ch_dly[0]` (B), and probe 2 compares `ch_in[2]` (A) with `ch_dly[2]` (B).
- R9: In test mode, probe 1 stays idle (`probe_act[1]`=0) whatever its inputs do.
- R10: Any change of `test_mode` returns all probes to idle at the next clock edge. Levels that are already high when the mode changes start no pulse.
- R11: `probe_pos` is 0 whenever the matching `probe_act` is 0, and it does not change while a pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| test_mode | input | 1 | 0 = rotating pair comparison, 1 = input-versus-delayed comparison |
| ch_in | input | NCH | Sliced channel inputs before the delay line |
| ch_dly | input | NCH | Sliced channel signals after the delay line |
| probe_act | output | NCH | Per-probe pulse active flag |
| probe_pos | output | NCH | Per-probe sign: 1 when side A led |

## Verification
A channel edge reaches the outputs after three rising edges: two synchronizer stages and one state register. The bench therefore drives every input at a falling edge and reads the outputs at falling edges, and it computes the expected first active sample as the leading edge's cycle plus three. Each pulse width is the count of active samples, and it must equal the gap between the two edges in cycles. A mode change acts after one edge, so the probes must read idle at the very next falling edge after the change.

// File: rtl/skew_pkg.sv
package skew_pkg;
  // Which side of a pair rose first; idle when no measurement is open.
  typedef enum logic [1:0] {
    PR_IDLE   = 2'd0,
    PR_A_LEAD = 2'd1,
    PR_B_LEAD = 2'd2
  } pair_state_e;
endpackage

// File: rtl/skew_rst_sync.sv
module skew_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/skew_sync.sv
module skew_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d;
      end else begin : g_rest
        always_comb stage_d = pipe_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= '0;
        else        pipe_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/skew_pair.sv
module skew_pair
  import skew_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic enable,
  input  logic a_lvl,
  input  logic b_lvl,
  output logic act,
  output logic pos
);
  pair_state_e state_q, state_d;
  logic a_q, b_q;
  logic rise_a, rise_b;

  // Previous levels are always loaded, including during a flush, so that
  // levels already high under a newly selected mode never look like edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_lvl;
      b_q <= b_lvl;
    end
  end

  assign rise_a = a_lvl & ~a_q;
  assign rise_b = b_lvl & ~b_q;

  always_comb begin
    state_d = state_q;
    if (flush || !enable) begin
      state_d = PR_IDLE;
    end else begin
      unique case (state_q)
        PR_IDLE: begin
          if (rise_a && !rise_b)      state_d = PR_A_LEAD;
          else if (rise_b && !rise_a) state_d = PR_B_LEAD;
        end
        PR_A_LEAD: if (rise_b || !a_lvl) state_d = PR_IDLE;
        PR_B_LEAD: if (rise_a || !b_lvl) state_d = PR_IDLE;
        default:   state_d = PR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PR_IDLE;
    else        state_q <= state_d;
  end

  assign act = (state_q != PR_IDLE);
  assign pos = (state_q == PR_A_LEAD);
endmodule

// File: rtl/skew_probe_top.sv
module skew_probe_top #(
  parameter int NCH         = 3,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  parameter int LEVEL_CH    = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           test_mode,
  input  logic [NCH-1:0] ch_in,
  input  logic [NCH-1:0] ch_dly,
  output logic [NCH-1:0] probe_act,
  output logic [NCH-1:0] probe_pos
);
  localparam int SW = 2 * NCH;

  logic          rst_i;
  logic [SW-1:0] raw_bus, sync_bus;
  logic [NCH-1:0] in_s, dly_s;
  logic          mode_q, mode_d;
  logic          flush;

  skew_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_i)
  );

  assign raw_bus = {ch_dly, ch_in};

  skew_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     (raw_bus),
    .q     (sync_bus)
  );

  assign in_s  = sync_bus[NCH-1:0];
  assign dly_s = sync_bus[SW-1:NCH];

  // Mode history: a difference between the live and last mode is a flush.
  always_comb mode_d = test_mode;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) mode_q <= 1'b0;
    else        mode_q <= mode_d;
  end

  assign flush = test_mode ^ mode_q;

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_probe
      localparam int PARTNER = (i + 1) % NCH;
      logic a_sel, b_sel, en;

      always_comb begin
        a_sel = test_mode ? in_s[i]  : dly_s[i];
        b_sel = test_mode ? dly_s[i] : dly_s[PARTNER];
      end

      if (i == LEVEL_CH) begin : g_level
        assign en = ~test_mode;
      end else begin : g_meas
        assign en = 1'b1;
      end

      skew_pair u_pair (
        .clk    (clk),
        .rst_n  (rst_i),
        .flush  (flush),
        .enable (en),
        .a_lvl  (a_sel),
        .b_lvl  (b_sel),
        .act    (probe_act[i]),
        .pos    (probe_pos[i])
      );
    end
  endgenerate
endmodule

// File: rtl/skew_probe_chk.sv
module skew_probe_chk #(
  parameter int NCH      = 3,
  parameter int LEVEL_CH = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           test_mode,
  input logic [NCH-1:0] probe_act,
  input logic [NCH-1:0] probe_pos
);
  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_chk
      // R11: no sign while idle
      p_idle_sign_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !probe_act[i] |-> !probe_pos[i]);

      // R11: sign held for the whole pulse
      p_sign_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_act[i] && $past(probe_act[i])) |-> $stable(probe_pos[i]));
    end
  endgenerate

  // R9: level probe silent once test mode has been seen at an edge
  p_level_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(test_mode) |-> !probe_act[LEVEL_CH]);

  // R10: a mode change empties every probe one edge later
  p_mode_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode != $past(test_mode)) |=> (probe_act == '0));
endmodule

bind skew_probe_top skew_probe_chk #(.NCH(NCH), .LEVEL_CH(LEVEL_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .test_mode (test_mode),
  .probe_act (probe_act),
  .probe_pos (probe_pos)
);

// File: tb/sim_skew_probe_top.sv
module sim_skew_probe_top;
  logic       clk;
  logic       rst_n;
  logic       test_mode;
  logic [2:0] ch_in;
  logic [2:0] ch_dly;
  logic [2:0] probe_act;
  logic [2:0] probe_pos;

  int checks;
  int failures;
  bit done;

  skew_probe_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .ch_in     (ch_in),
    .ch_dly    (ch_dly),
    .probe_act (probe_act),
    .probe_pos (probe_pos)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int actual, input int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic idle_gap();
    ch_in  = '0;
    ch_dly = '0;
    repeat (8) @(negedge clk);
  endtask

  // Inputs indexed 0..2 = ch_in, 3..5 = ch_dly; -1 means no event.
  task automatic run_case(input string name, input int rise [6], input int fall [6],
                          input int exp_w [3], input int exp_pos [3],
                          input int exp_start [3], input string tag [3]);
    int w [3];
    int start [3];
    int seen_hi [3];
    int seen_lo [3];
    int idle_sign;
    idle_sign = 0;
    for (int p = 0; p < 3; p++) begin
      w[p] = 0; start[p] = -1; seen_hi[p] = 0; seen_lo[p] = 0;
    end
    for (int c = 0; c < 24; c++) begin
      for (int p = 0; p < 3; p++) begin
        if (probe_act[p]) begin
          w[p]++;
          if (start[p] < 0) start[p] = c;
          if (probe_pos[p]) seen_hi[p] = 1; else seen_lo[p] = 1;
        end else if (probe_pos[p]) begin
          idle_sign = 1;
        end
      end
      for (int j = 0; j < 6; j++) begin
        if (rise[j] == c) begin
          if (j < 3) ch_in[j] = 1'b1; else ch_dly[j-3] = 1'b1;
        end
        if (fall[j] == c) begin
          if (j < 3) ch_in[j] = 1'b0; else ch_dly[j-3] = 1'b0;
        end
      end
      @(negedge clk);
    end
    for (int p = 0; p < 3; p++) begin
      chk(w[p] == exp_w[p], tag[p], $sformatf("%s probe%0d width", name, p), w[p], exp_w[p]);
      if (exp_w[p] > 0) begin
        // R5: first active sample three edges after the leading edge
        chk(start[p] == exp_start[p], "R5", $sformatf("%s probe%0d start", name, p),
            start[p], exp_start[p]);
        if (exp_pos[p] != 0)
          chk(seen_hi[p] == 1 && seen_lo[p] == 0, tag[p],
              $sformatf("%s probe%0d sign positive", name, p), seen_lo[p], 0);
        else
          chk(seen_lo[p] == 1 && seen_hi[p] == 0, tag[p],
              $sformatf("%s probe%0d sign negative", name, p), seen_hi[p], 0);
      end
    end
    chk(idle_sign == 0, "R11", {name, " sign while idle"}, idle_sign, 0);
    idle_gap();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; test_mode = 1'b0; ch_in = '0; ch_dly = '0;
    repeat (3) @(negedge clk);
    chk(probe_act == 3'b000, "R1", "act in reset", probe_act, 0);
    chk(probe_pos == 3'b000, "R1", "pos in reset", probe_pos, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(probe_act == 3'b000 && probe_pos == 3'b000, "R1", "idle after release",
        {probe_act, probe_pos}, 0);
  endtask

  // R2 R3: rotation red->green->blue, A leads on two pairs, B leads on the wrap pair
  task automatic t_rotation();
    run_case("rotation", '{-1, -1, -1, 0, 4, 6}, '{-1, -1, -1, 20, 20, 20},
             '{4, 2, 6}, '{1, 1, 0}, '{3, 7, 3}, '{"R3", "R2", "R2"});
  endtask

  // R4 R6: green and blue rise together, red late
  task automatic t_b_lead_coincident();
    run_case("blead", '{-1, -1, -1, 5, 2, 2}, '{-1, -1, -1, 15, 15, 15},
             '{3, 0, 3}, '{0, 0, 1}, '{5, 0, 5}, '{"R4", "R6", "R2"});
  endtask

  // R7: red rises and falls with no partner edge; both probes drop
  task automatic t_drop();
    run_case("drop", '{-1, -1, -1, 0, -1, -1}, '{-1, -1, -1, 3, -1, -1},
             '{3, 0, 3}, '{1, 0, 0}, '{3, 0, 3}, '{"R7", "R7", "R7"});
  endtask

  // R8 R9: test mode, input versus own delayed copy
  task automatic t_test_mode();
    test_mode = 1'b1;
    repeat (8) @(negedge clk);
    run_case("testmode", '{0, 0, 1, 5, 7, 3}, '{15, 15, 15, 15, 15, 15},
             '{5, 0, 2}, '{1, 0, 1}, '{3, 0, 4}, '{"R8", "R9", "R8"});
    test_mode = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // R10: mode change mid-pulse and with levels already high
  task automatic t_mode_flush();
    ch_dly[0] = 1'b1;
    repeat (4) @(negedge clk);
    chk(probe_act == 3'b101, "R10", "pulses open before switch", probe_act, 3'b101);
    test_mode = 1'b1;
    @(negedge clk);
    chk(probe_act == 3'b000, "R10", "idle one edge after switch", probe_act, 0);
    repeat (6) @(negedge clk);
    chk(probe_act == 3'b000, "R10", "no pulse from high level in test mode", probe_act, 0);
    test_mode = 1'b0;
    @(negedge clk);
    chk(probe_act == 3'b000, "R10", "idle one edge after return", probe_act, 0);
    repeat (6) @(negedge clk);
    chk(probe_act == 3'b000, "R10", "no pulse from high level in normal mode", probe_act, 0);
    idle_gap();
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    t_reset();
    t_rotation();
    t_b_lead_coincident();
    t_drop();
    t_test_mode();
    t_mode_flush();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule